// File: doc/BRIEF.md
# Three-Channel Timer Counter

The block holds three independent 16-bit up-counters. One input clock serves all three, and each counter has its own optional power-of-two prescaler. Each channel can run freely and wrap, or count up to a programmable limit and reload from zero. Three compare registers per channel flag chosen count values. Every event is latched into a sticky status register. A per-channel enable mask decides which status bits drive that channel's interrupt line.

Software reaches the block through a plain 32-bit write/read port. The read data is combinational from the address. The register group selects the base offset, in steps of 12 bytes. The channel index adds 4 bytes per channel. So register group g of channel c sits at byte address 12·g + 4·c. The usual service routine reads a status register and writes the same value back to acknowledge it.

Top module: `tri_timer`

## Requirements
- R1: After reset every counter reads 0, every status register reads 0, every irq bit is 0, and every counter-control register reads 0x1 (stopped).
- R2: Register group g of channel c is at byte address 12·g + 4·c. The groups are: 0 clock setup, 1 counter control, 2 count (read-only), 3 limit, 4/5/6 compare 1/2/3, 7 status, 8 irq enable. A read of an unaligned address, or of one past group 8, returns 0.
- R3: Counter-control bit 0 set stops the count, which then holds its value; clearing it resumes counting from the held value.
- R4: Writing counter control with bit 4 set zeroes the count and the prescaler at that write's clock edge. Bit 4 always reads back as 0.
- R5: With counter-control bit 1 clear, the count runs 0 to 0xFFFF, wraps to 0, and never sets status bit 0.
- R6: With counter-control bit 1 set, a tick taken while the count equals the limit reloads the count to 0 and sets status bit 0. The count never exceeds the limit.
- R7: A tick taken while the count equals compare register k (k = 1..3) sets status bit k.
- R8: Clock-setup bit 0 enables the prescaler. Bits 4:1 hold N, and the counter then advances once every 2^(N+1) clocks. With bit 0 clear it advances every clock.
- R9: Status bits are sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: irq[c] is high exactly when some status bit of channel c is set and its enable bit (same position, irq-enable register) is 1.
- R11: Writes to one channel leave the other channels' counts and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W (8) | Byte address for both write and read |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Combinational read data for addr |
| irq | output | NUM_CH (3) | One interrupt line per channel |

## Verification
A write takes effect at the clock edge that samples it. A write of bit 4 or a status acknowledge acts on the count or status at that same edge. A run or mode change is first used at the following edge. Each clock tick moves the count and sets any status bit at that edge, and irq follows the status register in the same cycle because it is combinational. Read data is combinational, so the bench drives inputs 1 ns after a rising edge and samples rdData and irq at the falling edge. A behavioural model steps at every rising edge and is compared every cycle. Directed checks count the edges since each write to set their expected counts.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  localparam int CNT_W       = 16;
  localparam int NUM_MATCH   = 3;
  localparam int STAT_W      = NUM_MATCH + 1;
  localparam int PRE_SEL_W   = 4;
  localparam int CLK_FIELD_W = PRE_SEL_W + 1;
  localparam int NUM_GRP     = 9;

  localparam int CTL_STOP_BIT = 0;
  localparam int CTL_INTV_BIT = 1;
  localparam int CTL_CLR_BIT  = 4;

  typedef enum logic [3:0] {
    GRP_CLK    = 4'd0,
    GRP_CTL    = 4'd1,
    GRP_COUNT  = 4'd2,
    GRP_LIMIT  = 4'd3,
    GRP_MATCH1 = 4'd4,
    GRP_MATCH2 = 4'd5,
    GRP_MATCH3 = 4'd6,
    GRP_STAT   = 4'd7,
    GRP_IEN    = 4'd8
  } regGrp_e;

  // Strobes and levels from the register side to one channel datapath
  typedef struct packed {
    logic                 run;
    logic                 intvMode;
    logic                 clrCount;
    logic                 preEn;
    logic [PRE_SEL_W-1:0] preSel;
    logic [STAT_W-1:0]    ackMask;
  } chanCmd_t;

endpackage

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  chanCmd_t                      cmd,
  input  logic [CNT_W-1:0]              limitVal,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0]              count,
  output logic [STAT_W-1:0]             status
);

  localparam int PRE_W = 1 << PRE_SEL_W;

  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preLimit;
  logic [PRE_W:0]     preSpan;
  logic               preDone;
  logic               tick;
  logic [STAT_W-1:0]  evt;

  always_comb begin
    preSpan  = (PRE_W+1)'(1) << ({1'b0, cmd.preSel} + 5'd1);
    preLimit = PRE_W'(preSpan - 1'b1);
    preDone  = !cmd.preEn || (preCnt >= preLimit);
    tick     = cmd.run && preDone && !cmd.clrCount;
  end

  assign evt[0] = tick && cmd.intvMode && (count == limitVal);

  generate
    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
      assign evt[k+1] = tick && (count == matchVal[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
      status <= '0;
    end else begin
      status <= (status & ~cmd.ackMask) | evt;
      if (cmd.clrCount) begin
        preCnt <= '0;
        count  <= '0;
      end else if (cmd.run) begin
        preCnt <= preDone ? '0 : preCnt + 1'b1;
        if (tick) begin
          count <= evt[0] ? '0 : count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tri_timer_ctrl.sv
module tri_timer_ctrl
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    wrEn,
  input  logic [ADDR_W-1:0]                       addr,
  input  logic [DATA_W-1:0]                       wrData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]            chanCount,
  input  logic [NUM_CH-1:0][STAT_W-1:0]           chanStatus,
  output chanCmd_t [NUM_CH-1:0]                   cmdVec,
  output logic [NUM_CH-1:0][CNT_W-1:0]            limitVal,
  output logic [NUM_CH-1:0][NUM_MATCH-1:0][CNT_W-1:0] matchVal,
  output logic [DATA_W-1:0]                       rdData,
  output logic [NUM_CH-1:0]                       irq
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CH_DIV = WORD_W'(NUM_CH);

  logic [WORD_W-1:0] wordIdx;
  logic [WORD_W-1:0] grpIdx;
  logic [WORD_W-1:0] chIdx;
  logic              inMap;

  assign wordIdx = addr[ADDR_W-1:2];
  assign grpIdx  = wordIdx / CH_DIV;
  assign chIdx   = wordIdx % CH_DIV;
  assign inMap   = (addr[1:0] == 2'b00) && (grpIdx < WORD_W'(NUM_GRP));

  logic [NUM_CH-1:0][CLK_FIELD_W-1:0] clkCfg;
  logic [NUM_CH-1:0][1:0]             ctlCfg;
  logic [NUM_CH-1:0][STAT_W-1:0]      ienCfg;
  logic [NUM_CH-1:0]                  chHit;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign chHit[c] = wrEn && inMap && (chIdx == WORD_W'(c));

      assign cmdVec[c].run      = !ctlCfg[c][CTL_STOP_BIT];
      assign cmdVec[c].intvMode = ctlCfg[c][CTL_INTV_BIT];
      assign cmdVec[c].clrCount = chHit[c] && (grpIdx == WORD_W'(GRP_CTL))
                                  && wrData[CTL_CLR_BIT];
      assign cmdVec[c].preEn    = clkCfg[c][0];
      assign cmdVec[c].preSel   = clkCfg[c][CLK_FIELD_W-1:1];
      assign cmdVec[c].ackMask  = (chHit[c] && (grpIdx == WORD_W'(GRP_STAT)))
                                  ? wrData[STAT_W-1:0] : '0;

      assign irq[c] = |(chanStatus[c] & ienCfg[c]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCfg   <= '0;
      ctlCfg   <= {NUM_CH{2'b01}};
      ienCfg   <= '0;
      limitVal <= '0;
      matchVal <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chHit[c]) begin
          if (grpIdx == WORD_W'(GRP_CLK))   clkCfg[c]   <= wrData[CLK_FIELD_W-1:0];
          if (grpIdx == WORD_W'(GRP_CTL))   ctlCfg[c]   <= wrData[1:0];
          if (grpIdx == WORD_W'(GRP_LIMIT)) limitVal[c] <= wrData[CNT_W-1:0];
          if (grpIdx == WORD_W'(GRP_IEN))   ienCfg[c]   <= wrData[STAT_W-1:0];
          for (int k = 0; k < NUM_MATCH; k++) begin
            if (grpIdx == WORD_W'(int'(GRP_MATCH1) + k)) matchVal[c][k] <= wrData[CNT_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (inMap) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chIdx == WORD_W'(c)) begin
          if (grpIdx == WORD_W'(GRP_CLK))   rdData = DATA_W'(clkCfg[c]);
          if (grpIdx == WORD_W'(GRP_CTL))   rdData = DATA_W'(ctlCfg[c]);
          if (grpIdx == WORD_W'(GRP_COUNT)) rdData = DATA_W'(chanCount[c]);
          if (grpIdx == WORD_W'(GRP_LIMIT)) rdData = DATA_W'(limitVal[c]);
          if (grpIdx == WORD_W'(GRP_STAT))  rdData = DATA_W'(chanStatus[c]);
          if (grpIdx == WORD_W'(GRP_IEN))   rdData = DATA_W'(ienCfg[c]);
          for (int k = 0; k < NUM_MATCH; k++) begin
            if (grpIdx == WORD_W'(int'(GRP_MATCH1) + k)) rdData = DATA_W'(matchVal[c][k]);
          end
        end
      end
    end
  end

endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq
);

  chanCmd_t [NUM_CH-1:0]                       cmdVec;
  logic [NUM_CH-1:0][CNT_W-1:0]                limitVal;
  logic [NUM_CH-1:0][NUM_MATCH-1:0][CNT_W-1:0] matchVal;
  logic [NUM_CH-1:0][CNT_W-1:0]                chanCount;
  logic [NUM_CH-1:0][STAT_W-1:0]               chanStatus;

  tri_timer_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .chanCount  (chanCount),
    .chanStatus (chanStatus),
    .cmdVec     (cmdVec),
    .limitVal   (limitVal),
    .matchVal   (matchVal),
    .rdData     (rdData),
    .irq        (irq)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      tri_timer_chan u_chan (
        .clk      (clk),
        .rstN     (rstN),
        .cmd      (cmdVec[c]),
        .limitVal (limitVal[c]),
        .matchVal (matchVal[c]),
        .count    (chanCount[c]),
        .status   (chanStatus[c])
      );
    end
  endgenerate

endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input chanCmd_t [NUM_CH-1:0]         cmdVec,
  input logic [NUM_CH-1:0][CNT_W-1:0]  chanCount,
  input logic [NUM_CH-1:0][STAT_W-1:0] chanStatus,
  input logic [NUM_CH-1:0][CNT_W-1:0]  limitVal,
  input logic [NUM_CH-1:0]             irq
);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
        (!cmdVec[c].run && !cmdVec[c].clrCount) |=> $stable(chanCount[c])); // R3

      AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        cmdVec[c].clrCount |=> (chanCount[c] == '0)); // R4

      AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(chanCount[c]) |->
          ((chanCount[c] == CNT_W'($past(chanCount[c]) + 1'b1)) || (chanCount[c] == '0))); // R5

      AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        (cmdVec[c].intvMode && (chanCount[c] <= limitVal[c]) && !wrEn)
          |=> (chanCount[c] <= limitVal[c])); // R6

      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        !wrEn |=> ((chanStatus[c] & $past(chanStatus[c])) == $past(chanStatus[c]))); // R9

      AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
        irq[c] |-> (chanStatus[c] != '0)); // R10
    end
  endgenerate

endmodule

bind tri_timer tri_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .cmdVec     (cmdVec),
  .chanCount  (chanCount),
  .chanStatus (chanStatus),
  .limitVal   (limitVal),
  .irq        (irq)
);

// File: tb/tri_timer_bench.sv
module tri_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  tri_timer u_tri_timer (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  int mCnt[3], mPre[3], mCtl[3], mClk[3], mLim[3], mIen[3], mSt[3];
  int mMat[3][3];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input int a);
    int w, g, c;
    if (a % 4 != 0) return 0;
    w = a / 4; g = w / 3; c = w % 3;
    case (g)
      0: return mClk[c];
      1: return mCtl[c];
      2: return mCnt[c];
      3: return mLim[c];
      4, 5, 6: return mMat[c][g-4];
      7: return mSt[c];
      8: return mIen[c];
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] modelIrq();
    logic [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = (mSt[c] & mIen[c]) != 0;
    return r;
  endfunction

  always @(posedge clk) begin
    int g, ack, evt, lim;
    bit sel, clr, done;
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin
        mCnt[c] = 0; mPre[c] = 0; mCtl[c] = 1; mClk[c] = 0;
        mLim[c] = 0; mIen[c] = 0; mSt[c] = 0;
        for (int k = 0; k < 3; k++) mMat[c][k] = 0;
      end
    end else begin
      g = (int'(addr) / 4) / 3;
      for (int c = 0; c < 3; c++) begin
        sel = wrEn && (addr % 4 == 0) && (g <= 8) && ((int'(addr) / 4) % 3 == c);
        clr = sel && (g == 1) && wrData[4];
        ack = (sel && g == 7) ? int'(wrData & 32'hF) : 0;
        evt = 0;
        if (clr) begin
          mCnt[c] = 0; mPre[c] = 0;
        end else if ((mCtl[c] & 1) == 0) begin
          lim  = (1 << (((mClk[c] >> 1) & 15) + 1)) - 1;
          done = ((mClk[c] & 1) == 0) || (mPre[c] >= lim);
          mPre[c] = done ? 0 : mPre[c] + 1;
          if (done) begin
            for (int k = 0; k < 3; k++) if (mCnt[c] == mMat[c][k]) evt |= (2 << k);
            if ((mCtl[c] & 2) != 0 && mCnt[c] == mLim[c]) begin
              evt |= 1; mCnt[c] = 0;
            end else mCnt[c] = (mCnt[c] + 1) & 16'hFFFF;
          end
        end
        mSt[c] = ((mSt[c] & ~ack) | evt) & 15;
        if (sel) begin
          case (g)
            0: mClk[c] = int'(wrData & 32'h1F);
            1: mCtl[c] = int'(wrData & 32'h3);
            3: mLim[c] = int'(wrData & 32'hFFFF);
            4, 5, 6: mMat[c][g-4] = int'(wrData & 32'hFFFF);
            8: mIen[c] = int'(wrData & 32'hF);
            default: ;
          endcase
        end
      end
    end
  end

  // Every-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 model rdData", rdData, modelRead(int'(addr)));
      check("R10 model irq", {29'b0, irq}, {29'b0, modelIrq()});
    end
  end

  // Tasks are entered 1 ns after a rising edge and leave 1 ns after one
  task automatic wr(input int a, input int d);
    wrEn = 1'b1; addr = 8'(a); wrData = 32'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = 8'(a); #1; v = rdData;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(8'h0C, v); check("R1 ctrl ch0", v, 32'h1);
    rd(8'h14, v); check("R1 ctrl ch2", v, 32'h1);
    rd(8'h18, v); check("R1 count ch0", v, 32'h0);
    rd(8'h54, v); check("R1 status ch0", v, 32'h0);
    check("R1 irq", {29'b0, irq}, 32'h0);

    // R3 stop and resume
    wr(8'h0C, 0); idle(10);
    rd(8'h18, v); check("R3 running count", v, 32'd10);
    wr(8'h0C, 1); idle(5);
    rd(8'h18, v); check("R3 held count", v, 32'd11);

    // R4 clear strobe
    wr(8'h0C, 8'h11);
    rd(8'h18, v); check("R4 cleared count", v, 32'd0);
    rd(8'h0C, v); check("R4 bit4 reads 0", v, 32'h1);

    // R8 prescaler
    wr(8'h00, 1); wr(8'h0C, 8'h10); idle(8);
    rd(8'h18, v); check("R8 divide by 2", v, 32'd4);
    wr(8'h00, 9); wr(8'h0C, 8'h10); idle(64);
    rd(8'h18, v); check("R8 divide by 32", v, 32'd2);
    idle(31); rd(8'h18, v); check("R8 before tick", v, 32'd2);
    idle(1);  rd(8'h18, v); check("R8 at tick", v, 32'd3);

    // R5 free-running wrap
    wr(8'h00, 0); wr(8'h0C, 8'h10); idle(65535);
    rd(8'h18, v); check("R5 top value", v, 32'hFFFF);
    idle(1);
    rd(8'h18, v); check("R5 wrapped", v, 32'h0);
    rd(8'h54, v); check("R5 no limit status", v & 32'h1, 32'h0);
    wr(8'h0C, 1);

    // R11 other channels untouched
    rd(8'h1C, v); check("R11 ch1 count", v, 32'h0);
    rd(8'h20, v); check("R11 ch2 count", v, 32'h0);
    rd(8'h5C, v); check("R11 ch2 status", v, 32'h0);

    // R6 limit mode on ch1
    wr(8'h28, 3); wr(8'h64, 1); wr(8'h10, 8'h12); idle(3);
    rd(8'h1C, v); check("R6 at limit", v, 32'd3);
    rd(8'h58, v); check("R6 no status yet", v & 32'h1, 32'h0);
    check("R10 irq low", {31'b0, irq[1]}, 32'h0);
    idle(1);
    rd(8'h1C, v); check("R6 reloaded", v, 32'd0);
    rd(8'h58, v); check("R6 status set", v & 32'h1, 32'h1);
    check("R10 irq high", {31'b0, irq[1]}, 32'h1);

    // R9 write-one-to-clear
    wr(8'h58, 0);
    rd(8'h58, v); check("R9 zero write keeps", v & 32'h1, 32'h1);
    wr(8'h58, 1);
    rd(8'h58, v); check("R9 one write clears", v & 32'h1, 32'h0);
    check("R10 irq dropped", {31'b0, irq[1]}, 32'h0);

    // R2 address map
    rd(8'h28, v); check("R2 limit ch1", v, 32'd3);
    rd(8'h6C, v); check("R2 past map", v, 32'h0);
    rd(8'h29, v); check("R2 unaligned", v, 32'h0);

    // R7 compare on ch2
    wr(8'h38, 5); wr(8'h44, 2); wr(8'h50, 9); wr(8'h14, 8'h10); idle(2);
    rd(8'h5C, v); check("R7 before match", v, 32'h0);
    idle(1);
    rd(8'h5C, v); check("R7 compare2", v, 32'h4);
    idle(3);
    rd(8'h5C, v); check("R7 compare1", v, 32'h6);
    check("R10 masked", {31'b0, irq[2]}, 32'h0);
    wr(8'h68, 4);
    check("R10 enabled", {31'b0, irq[2]}, 32'h1);
    wr(8'h5C, 2);
    rd(8'h5C, v); check("R9 partial clear", v, 32'h4);
    wr(8'h5C, 4);
    rd(8'h5C, v); check("R9 full clear", v, 32'h0);
    check("R10 irq off", {31'b0, irq[2]}, 32'h0);
    idle(1);
    rd(8'h5C, v); check("R7 compare3", v, 32'h8);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule